// File: doc/BRIEF.md
# Power-Fail NMI Trap Controller

This block watches an active-low power-fail pin and turns its high-to-low transition into a non-maskable interrupt request for the processor. The pin is asynchronous. It passes through a synchronizer chain, and then an edge detector compares the current synchronized level with the level one cycle earlier. Each recognised falling edge sets a sticky status flag. If the trap is armed at that moment, the block also emits a one-cycle trap pulse.

Firmware sees two byte-wide registers on a simple strobed bus. The status register is read-only, and reading it clears it. The control register holds a single arm bit. Hardware drops the arm bit as soon as a trap fires, so firmware must re-arm after every event. Read data is registered and appears one cycle after the read strobe.

Top module: `pfail_nmi_ctrl`

## Requirements
- R1: After a synchronous reset, the status flag, the arm bit, `bus_rdata` and `nmi_trap` are all 0.
- R2: A high-to-low transition of `pf_n` sets the status flag, which is bit 0 of the status register at address 0. A low-to-high transition does not set it, and a pin held low sets it only once.
- R3: A read of address 0 returns the status flag in bit 0 and zeros in bits 7..1, and it clears the flag. An immediately following read returns 0x00.
- R4: If a falling edge is recognised in the same cycle as a status read, that read returns the old value and the flag is left set.
- R5: The control register at address 1 holds the arm bit in bit 0. Writes to bit 0 set or clear it, and it reads back as {7'b0, arm}. Bits 7..1 ignore writes and read 0.
- R6: When armed, a falling edge produces exactly one `nmi_trap` pulse that is one clock cycle wide.
- R7: The arm bit clears itself when a trap fires. A later falling edge without re-arming sets the status flag but gives no trap.
- R8: While disarmed, a falling edge gives no trap but still sets the status flag.
- R9: If a firmware write of 1 to the arm bit lands in the same cycle as a trap, the hardware clear wins and the arm bit reads back 0.
- R10: Writes to the status register have no effect, and status reads do not change the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_n | input | 1 | Asynchronous active-low power-fail pin |
| bus_cs | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address (0 status, 1 control) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after the read strobe |
| nmi_trap | output | 1 | One-cycle non-maskable trap request |

## Verification
The pin is dropped in four situations: while disarmed, while armed, while disarmed again after a trap has fired, and while armed with a same-cycle firmware write of 1. Together these separate status setting from trap gating and from the self-clearing arm bit. A rising edge and a long low hold show whether the detector reacts only to falls. A read aligned exactly with the recognised edge shows whether the set-over-clear priority keeps the event. Writes of 0xFE and 0xFF, and writes aimed at the status address, show that reserved bits and the read-only register ignore writes.

// File: rtl/pfnmi_pkg.sv
package pfnmi_pkg;

  // Register selection decoded from the bus address
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  // Bit positions inside the byte registers
  localparam int FLAG_BIT = 0;
  localparam int ARM_BIT  = 0;

endpackage

// File: rtl/pfnmi_sync.sv
module pfnmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/pfnmi_edge.sv
module pfnmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);

  logic prev_q;

  // prev resets low: a pin that is already low at reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  // A fall needs a high level in between, so two in a row cannot occur
  p_fall_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall)
    else $error("p_fall_isolated_r2");

endmodule

// File: rtl/pfnmi_regs.sv
module pfnmi_regs
  import pfnmi_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              nmi
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  reg_sel_e          sel;
  logic              stat_q;
  logic              arm_q;
  logic              nmi_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fire;
  logic              rd_stat;
  logic              wr_ctrl;

  always_comb begin
    sel = SEL_NONE;
    if (cs) begin
      if (addr == STAT_A)      sel = SEL_STAT;
      else if (addr == CTRL_A) sel = SEL_CTRL;
    end
  end

  assign rd_stat = rd && (sel == SEL_STAT);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign fire    = fall && arm_q;

  // Status flag: a new edge wins over a clearing read
  always_ff @(posedge clk) begin
    if (rst)          stat_q <= 1'b0;
    else if (fall)    stat_q <= 1'b1;
    else if (rd_stat) stat_q <= 1'b0;
  end

  // Arm bit: a firing trap wins over a firmware write
  always_ff @(posedge clk) begin
    if (rst)          arm_q <= 1'b0;
    else if (fire)    arm_q <= 1'b0;
    else if (wr_ctrl) arm_q <= wdata[ARM_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) nmi_q <= 1'b0;
    else     nmi_q <= fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (sel)
        SEL_STAT: rdata_q <= DATA_W'(stat_q);
        SEL_CTRL: rdata_q <= DATA_W'(arm_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign nmi   = nmi_q;

  p_trap_single_r6: assert property (@(posedge clk) disable iff (rst)
    nmi_q |=> !nmi_q)
    else $error("p_trap_single_r6");

  p_disarmed_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (fall && !arm_q) |=> !nmi_q)
    else $error("p_disarmed_quiet_r8");

  p_arm_consumed_r7: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> !arm_q)
    else $error("p_arm_consumed_r7");

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    fall |=> stat_q)
    else $error("p_set_wins_r4");

  p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !fall) |=> !stat_q)
    else $error("p_read_clears_r3");

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:1] == '0)
    else $error("p_reserved_zero_r5");

endmodule

// File: rtl/pfail_nmi_ctrl.sv
module pfail_nmi_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 1,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_ADDR   = 0,
  parameter int CTRL_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              nmi_trap
);

  logic pf_sync;
  logic pf_fall;

  pfnmi_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pf_n),
    .q   (pf_sync)
  );

  pfnmi_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pf_sync),
    .fall (pf_fall)
  );

  pfnmi_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .fall  (pf_fall),
    .cs    (bus_cs),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .nmi   (nmi_trap)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!nmi_trap && bus_rdata == '0))
    else $error("p_reset_quiet_r1");

endmodule

// File: tb/tb_pfail_nmi_ctrl.sv
module tb_pfail_nmi_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pf_n = 1'b1;
  logic       bus_cs = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [0:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       nmi_trap;

  int n_checks = 0;
  int n_fail   = 0;
  int trap_cnt = 0;
  bit done     = 0;
  bit rd_seen  = 0;
  bit nmi_prev = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2 clk = ~clk;

  pfail_nmi_ctrl dut (
    .clk       (clk),
    .rst       (rst),
    .pf_n      (pf_n),
    .bus_cs    (bus_cs),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .nmi_trap  (nmi_trap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pf_n = v;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: note reads at the edge, compare registered data half a cycle later
  always @(posedge clk) rd_seen <= bus_cs && bus_rd && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(bus_rdata == e, r, bus_rdata, e);
    end
    if (!rst && nmi_trap) begin
      trap_cnt++;
      check(!nmi_prev, "R6 pulse width", 1, 0);
    end
    nmi_prev <= nmi_trap;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(nmi_trap == 0, "R1 nmi", nmi_trap, 0);
    check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    bus_read(0, 8'h00, "R1 status");
    bus_read(1, 8'h00, "R1 arm");
    repeat (4) @(negedge clk);

    // Disarmed fall: flag set, no trap
    set_pin(0);
    check(trap_cnt == 0, "R8 no trap", trap_cnt, 0);
    bus_read(0, 8'h01, "R8 flag set");
    bus_read(0, 8'h00, "R3 cleared by read");
    repeat (6) @(negedge clk);
    bus_read(0, 8'h00, "R2 held low sets once");
    set_pin(1);
    bus_read(0, 8'h00, "R2 rising no set");

    // Control register and reserved bits
    bus_write(1, 8'hFE);
    bus_read(1, 8'h00, "R5 reserved ignored");
    bus_write(1, 8'hFF);
    bus_read(1, 8'h01, "R5 arm set");
    bus_write(1, 8'h00);
    bus_read(1, 8'h00, "R5 arm cleared");
    bus_write(1, 8'h01);

    // Status register is read-only; reads leave arm untouched
    bus_write(0, 8'hFF);
    bus_read(0, 8'h00, "R10 status write ignored");
    bus_read(1, 8'h01, "R10 arm kept");

    // Armed fall
    set_pin(0);
    check(trap_cnt == 1, "R6 one trap", trap_cnt, 1);
    bus_read(1, 8'h00, "R7 arm self-cleared");
    bus_read(0, 8'h01, "R6 flag set");
    set_pin(1);

    // Fall without re-arm
    set_pin(0);
    check(trap_cnt == 1, "R7 no second trap", trap_cnt, 1);
    bus_read(0, 8'h01, "R7 flag set");
    set_pin(1);

    // Edge recognised in the same cycle as a status read
    @(negedge clk); pf_n = 0;
    @(negedge clk);
    bus_read(0, 8'h00, "R4 old value");
    bus_read(0, 8'h01, "R4 flag kept");
    set_pin(1);

    // Arm write colliding with a firing trap
    bus_write(1, 8'h01);
    @(negedge clk); pf_n = 0;
    @(negedge clk);
    bus_write(1, 8'h01);
    repeat (4) @(negedge clk);
    check(trap_cnt == 2, "R9 trap fired", trap_cnt, 2);
    bus_read(1, 8'h00, "R9 clear wins");
    bus_read(0, 8'h01, "R9 flag set");
    set_pin(1);

    // Firmware disarm prevents the trap
    bus_write(1, 8'h01);
    bus_write(1, 8'h00);
    set_pin(0);
    check(trap_cnt == 2, "R5 disarmed by write", trap_cnt, 2);
    bus_read(0, 8'h01, "R8 flag set again");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 reads drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule